// File: doc/BRIEF.md
# Word-Serial Modular Adder/Subtractor

This block adds or subtracts two operands modulo a fixed prime `q`. Each operand is 256 bits wide and is split into eight 32-bit words. It uses one clock cycle per word and starts from the least significant word. The operands come from an external word store: the block drives `op_idx`, and the surrounding logic returns the matching `a_word` and `b_word` in the same cycle.

For every word the block computes two candidates side by side, each with its own carry or borrow chain:

- **Add mode:** the plain sum, and the sum with `q` subtracted.
- **Subtract mode:** the plain difference, and the difference with `q` added.

Both candidates are written into small word buffers. After the most significant word, the final carry and borrow flags pick one candidate, so no compare-then-correct pass is needed. The chosen result is read one word at a time through `res_sel` and `res_word`, and stays unchanged until the next accepted start.

The controller has three states:

- **ST_IDLE** — waits for `start`.
- **ST_RUN** — walks word indices 0 to 7.
- **ST_DONE** — asserts `done` for one cycle.

Transitions:

- ST_IDLE → ST_RUN on `start`.
- ST_RUN → ST_RUN while the index is below 7.
- ST_RUN → ST_DONE after word 7.
- ST_DONE → ST_RUN if `start` is high.
- ST_DONE → ST_IDLE otherwise.

Operands are assumed to be already reduced, i.e. below `q`.

Top module: `modq_addsub_serial`

## Requirements
- R1: After reset `done` is 0 and `res_word` is 0 for every `res_sel` value 0..7.
- R2: When `start` is sampled high in ST_IDLE or ST_DONE, `done` is high during exactly the ninth cycle after that clock edge, for one cycle only.
- R3: During ST_RUN, `op_idx` counts 0,1,...,7 on successive cycles; word index i holds operand bits [32i+31:32i].
- R4: With `mode`=0 (add) and a, b < q, the result equals (a+b) mod q. This includes a+b = q (result 0) and a+b ≥ 2^256.
- R5: With `mode`=0, when a+b < q the result is the unmodified sum a+b.
- R6: With `mode`=1 (subtract) and a, b < q, the result equals (a−b) mod q. When a < b, q is added; a = b gives 0.
- R7: `mode` is sampled only with `start`; changing it during ST_RUN has no effect on the result.
- R8: A `start` pulse during ST_RUN is ignored: timing and result of the running operation are unchanged, and no extra `done` follows.
- R9: Outside ST_RUN the result read through `res_sel`/`res_word` stays unchanged until the next accepted start, whatever `mode`, `a_word` and `b_word` do.
- R10: For reduced operands every result word set read back is a value below q.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin an operation |
| mode | input | 1 | 0 = modular add, 1 = modular subtract; sampled with start |
| op_idx | output | 3 | Index of the operand word requested this cycle |
| a_word | input | 32 | Word `op_idx` of operand a |
| b_word | input | 32 | Word `op_idx` of operand b |
| res_sel | input | 3 | Index of the result word to read |
| res_word | output | 32 | Result word `res_sel` (combinational read) |
| done | output | 1 | One-cycle pulse marking a finished result |

## Verification
Add mode is tried with several kinds of operands:

- Zero operands.
- Sums below q, which must keep the plain candidate.
- A sum exactly equal to q, where the borrow from subtracting q is cleared.
- q−1 plus q−1, which carries out of 256 bits so the carry cancels the borrow.

Subtract mode is tried with:

- a > b.
- a = b.
- a < b, including 0 − (q−1), which must take the corrected candidate.

Pseudo-random reduced operands in both modes check agreement with a 257-bit reference across many carry patterns. Mode flips and start pulses during a run, and idle-period input changes, show that only the values sampled at start matter.

// File: rtl/modq_pkg.sv
package modq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } modq_state_e;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } modq_op_e;
endpackage

// File: rtl/modq_word_slice.sv
module modq_word_slice #(
    parameter int WORD_W = 32
) (
    input  logic              op_sub,
    input  logic [WORD_W-1:0] a_w,
    input  logic [WORD_W-1:0] b_w,
    input  logic [WORD_W-1:0] q_w,
    input  logic              prim_fi,
    input  logic              corr_fi,
    output logic [WORD_W-1:0] prim_w,
    output logic [WORD_W-1:0] corr_w,
    output logic              prim_fo,
    output logic              corr_fo
);
    logic [WORD_W:0] prim_ext;
    logic [WORD_W:0] corr_ext;

    always_comb begin
        if (op_sub) begin
            // Primary chain: a - b with borrow; correction chain: + q with carry
            prim_ext = {1'b0, a_w} - {1'b0, b_w} - {{WORD_W{1'b0}}, prim_fi};
            corr_ext = {1'b0, prim_ext[WORD_W-1:0]} + {1'b0, q_w}
                     + {{WORD_W{1'b0}}, corr_fi};
        end else begin
            // Primary chain: a + b with carry; correction chain: - q with borrow
            prim_ext = {1'b0, a_w} + {1'b0, b_w} + {{WORD_W{1'b0}}, prim_fi};
            corr_ext = {1'b0, prim_ext[WORD_W-1:0]} - {1'b0, q_w}
                     - {{WORD_W{1'b0}}, corr_fi};
        end
        prim_w  = prim_ext[WORD_W-1:0];
        corr_w  = corr_ext[WORD_W-1:0];
        prim_fo = prim_ext[WORD_W];
        corr_fo = corr_ext[WORD_W];
    end
endmodule

// File: rtl/modq_cand_store.sv
module modq_cand_store #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 8,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] prim_in,
    input  logic [WORD_W-1:0] corr_in,
    input  logic              pick_corr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] prim_buf [NUM_WORDS];
    logic [WORD_W-1:0] corr_buf [NUM_WORDS];

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prim_buf[g] <= '0;
                corr_buf[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                prim_buf[g] <= prim_in;
                corr_buf[g] <= corr_in;
            end
        end
    end

    assign rd_word = pick_corr ? corr_buf[rd_idx] : prim_buf[rd_idx];
endmodule

// File: rtl/modq_seq_ctrl.sv
module modq_seq_ctrl
    import modq_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output modq_state_e      state,
    output logic [IDX_W-1:0] idx,
    output logic             accept,
    output logic             step,
    output logic             last,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

    modq_state_e state_nx;
    logic [IDX_W-1:0] idx_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
        end
    end

    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = ST_RUN;
                    idx_nx   = '0;
                end
            end
            ST_RUN: begin
                if (idx == LAST_IDX) begin
                    state_nx = ST_DONE;
                    idx_nx   = '0;
                end else begin
                    idx_nx = idx + 1'b1;
                end
            end
            ST_DONE: begin
                state_nx = start ? ST_RUN : ST_IDLE;
                idx_nx   = '0;
            end
            default: begin
                state_nx = ST_IDLE;
                idx_nx   = '0;
            end
        endcase
    end

    always_comb begin
        accept = 1'b0;
        step   = 1'b0;
        last   = 1'b0;
        done   = 1'b0;
        unique case (state)
            ST_IDLE: accept = start;
            ST_RUN: begin
                step = 1'b1;
                last = (idx == LAST_IDX);
            end
            ST_DONE: begin
                done   = 1'b1;
                accept = start;
            end
            default: ;
        endcase
    end

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && idx != LAST_IDX) |=> (state == ST_RUN && idx == $past(idx) + 1'b1)); // R3
    AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |=> (state != ST_RUN || idx == '0)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && idx != LAST_IDX && start) |=> (state == ST_RUN)); // R8
endmodule

// File: rtl/modq_addsub_serial.sv
module modq_addsub_serial
    import modq_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 8,
    parameter logic [NUM_WORDS*WORD_W-1:0] MODULUS =
        256'hFFFFFFFF_00000001_00000000_00000000_00000000_FFFFFFFF_FFFFFFFF_FFFFFFFF,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    output logic [IDX_W-1:0]  op_idx,
    input  logic [WORD_W-1:0] a_word,
    input  logic [WORD_W-1:0] b_word,
    input  logic [IDX_W-1:0]  res_sel,
    output logic [WORD_W-1:0] res_word,
    output logic              done
);
    modq_state_e      state;
    logic [IDX_W-1:0] idx;
    logic             accept, step, last;

    modq_op_e         op_q;
    logic             prim_f, corr_f;
    logic             sel_corr;

    logic [WORD_W-1:0] q_w, prim_w, corr_w;
    logic              prim_fo, corr_fo;
    logic              pick_now;

    modq_seq_ctrl #(.NUM_WORDS(NUM_WORDS)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .state  (state),
        .idx    (idx),
        .accept (accept),
        .step   (step),
        .last   (last),
        .done   (done)
    );

    assign op_idx = idx;
    assign q_w    = MODULUS[idx*WORD_W +: WORD_W];

    modq_word_slice #(.WORD_W(WORD_W)) u_slice (
        .op_sub  (op_q == OP_SUB),
        .a_w     (a_word),
        .b_w     (b_word),
        .q_w     (q_w),
        .prim_fi (prim_f),
        .corr_fi (corr_f),
        .prim_w  (prim_w),
        .corr_w  (corr_w),
        .prim_fo (prim_fo),
        .corr_fo (corr_fo)
    );

    // Final choice: add keeps the plain sum only if the q-subtraction borrowed
    // without a sum carry; subtract takes the corrected value if a-b borrowed.
    assign pick_now = (op_q == OP_SUB) ? prim_fo : !(corr_fo && !prim_fo);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_ADD;
            prim_f   <= 1'b0;
            corr_f   <= 1'b0;
            sel_corr <= 1'b0;
        end else if (accept) begin
            op_q   <= modq_op_e'(mode);
            prim_f <= 1'b0;
            corr_f <= 1'b0;
        end else if (step) begin
            prim_f <= prim_fo;
            corr_f <= corr_fo;
            if (last) begin
                sel_corr <= pick_now;
            end
        end
    end

    modq_cand_store #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (step),
        .wr_idx    (idx),
        .prim_in   (prim_w),
        .corr_in   (corr_w),
        .pick_corr (sel_corr),
        .rd_idx    (res_sel),
        .rd_word   (res_word)
    );

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> $stable(op_q)); // R7
    AST_CHOICE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> $stable(sel_corr)); // R9
    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state == ST_RUN && idx == IDX_W'(NUM_WORDS - 1))); // R2
    AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!prim_f && !corr_f)); // R3
endmodule

// File: tb/test_modq_addsub_serial.sv
`timescale 1ns/1ps
module test_modq_addsub_serial;
    localparam logic [255:0] Q =
        256'hFFFFFFFF_00000001_00000000_00000000_00000000_FFFFFFFF_FFFFFFFF_FFFFFFFF;
    localparam int NV = 10;
    // Vector table: operand a, operand b, mode (0 add, 1 sub)
    localparam logic [255:0] VA [NV] = '{
        256'd0, Q - 256'd1, Q - 256'd1, 256'h1234_5678_9ABC_DEF0,
        Q - 256'h1234_5678_9ABC_DEF0, 256'd5, Q - 256'd77, 256'd0,
        Q - 256'd1, 256'hDEAD_BEEF_0000_0000_CAFE_F00D_0000_0001_2345_6789};
    localparam logic [255:0] VB [NV] = '{
        256'd0, 256'd1, Q - 256'd1, 256'h1111,
        256'h1234_5678_9ABC_DEF0, 256'd7, Q - 256'd77, Q - 256'd1,
        256'd0, 256'hFFFF_0000_FFFF_0000_1111_2222_3333_4444};
    localparam logic VM [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mode = 1'b0;
    logic [2:0] op_idx;
    logic [31:0] a_word, b_word, res_word;
    logic [2:0] res_sel = 3'd0;
    logic done;
    logic [255:0] cur_a = '0, cur_b = '0;
    int checks = 0, failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    assign a_word = cur_a[op_idx*32 +: 32];
    assign b_word = cur_b[op_idx*32 +: 32];

    modq_addsub_serial i_modq_addsub_serial (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .op_idx(op_idx), .a_word(a_word), .b_word(b_word),
        .res_sel(res_sel), .res_word(res_word), .done(done));

    function automatic logic [255:0] ref_op(logic [255:0] a, logic [255:0] b, logic m);
        logic [256:0] t;
        if (!m) begin
            t = {1'b0, a} + {1'b0, b};
            if (t >= {1'b0, Q}) t = t - {1'b0, Q};
        end else begin
            if (a >= b) t = {1'b0, a} - {1'b0, b};
            else        t = {1'b0, a} + {1'b0, Q} - {1'b0, b};
        end
        return t[255:0];
    endfunction

    task automatic check(string req, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_result(output logic [255:0] r);
        for (int i = 0; i < 8; i++) begin
            res_sel = 3'(i);
            #0.1;
            r[i*32 +: 32] = res_word;
        end
    endtask

    // Runs one operation; optional disturbance at cycle 4: flip mode (R7) or pulse start (R8)
    task automatic run_op(logic [255:0] a, logic [255:0] b, logic m, int disturb,
                          output int lat, output logic [255:0] r);
        @(negedge clk);
        cur_a = a; cur_b = b; mode = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 30) begin
            if (lat == 4 && disturb == 1) mode = ~m;
            if (lat == 4 && disturb == 2) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        read_result(r);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [255:0] r, exp, ra, rb;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 done", {255'd0, done}, 256'd0);
        read_result(r);
        check("R1 result", r, 256'd0);
        rst_n = 1'b1;

        // Vector table: R2 latency, R4/R5/R6 value, R10 range
        for (int v = 0; v < NV; v++) begin
            run_op(VA[v], VB[v], VM[v], 0, lat, r);
            exp = ref_op(VA[v], VB[v], VM[v]);
            check("R2 latency", 256'(lat), 256'd9);
            check(VM[v] ? "R6 sub value" : "R4 add value", r, exp);
            check("R10 below q", {255'd0, (r < Q)}, 256'd1);
        end

        // R5: small sum stays plain
        run_op(256'd100, 256'd23, 1'b0, 0, lat, r);
        check("R5 plain sum", r, 256'd123);
        // R4: a+b exactly q gives zero
        run_op(Q - 256'd9, 256'd9, 1'b0, 0, lat, r);
        check("R4 sum equals q", r, 256'd0);
        // R6: a<b wraps by q
        run_op(256'd3, 256'd10, 1'b1, 0, lat, r);
        check("R6 wrap", r, Q - 256'd7);
        // R3: top-word-only operands exercise word ordering
        run_op(256'd1 << 240, 256'd1 << 200, 1'b1, 0, lat, r);
        check("R3 word order", r, (256'd1 << 240) - (256'd1 << 200));

        // R7: mode flip mid-run has no effect
        run_op(256'd50, 256'd20, 1'b1, 1, lat, r);
        check("R7 mode sampled", r, 256'd30);
        check("R7 latency", 256'(lat), 256'd9);

        // R8: start pulse mid-run ignored
        run_op(256'd50, 256'd20, 1'b0, 2, lat, r);
        check("R8 latency", 256'(lat), 256'd9);
        check("R8 value", r, 256'd70);
        begin
            int extra = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (done) extra++;
            end
            check("R8 no extra done", 256'(extra), 256'd0);
        end

        // R9: result held while idle despite input changes
        cur_a = Q - 256'd1; cur_b = Q - 256'd2; mode = 1'b1;
        repeat (20) @(negedge clk);
        read_result(r);
        check("R9 hold", r, 256'd70);
        check("R9 done low", {255'd0, done}, 256'd0);

        // Pseudo-random reduced operands, both modes
        for (int n = 0; n < 24; n++) begin
            for (int w = 0; w < 8; w++) begin
                ra[w*32 +: 32] = $urandom;
                rb[w*32 +: 32] = $urandom;
            end
            if (ra >= Q) ra = ra - Q;
            if (rb >= Q) rb = rb - Q;
            run_op(ra, rb, n[0], 0, lat, r);
            check(n[0] ? "R6 random" : "R4 random", r, ref_op(ra, rb, n[0]));
            check("R10 random range", {255'd0, (r < Q)}, 256'd1);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule